// File: doc/BRIEF.md
# Link Self-Test Pattern Sequencer

This block is the transmit half of a built-in self-test engine for a multi-lane serial link. Software loads an eight-entry symbol pattern and a 20-bit control word while the block is idle, then pulses `start`. The sequencer drives the lanes with the pattern, one entry per symbol time on every lane, in sets of eight symbol times. It can optionally open with a short run of training symbol times. It can slip a one-cycle skip symbol time in between sets, and it can stamp a delay symbol onto a chosen group of lanes. It always closes the run with one electrical-idle symbol time.

A run ends in one of three ways: the programmed number of sets completes, a stop request arrives in continuous mode, or the receiver-side checker reports an error while stop-on-error is enabled. The checker is reduced here to an error pulse with a lane mask. An error status holds the index of the set in progress and the failing lanes. Its valid bit stays set until software clears it.

Control word layout (`cfgWrData`): bit 19 forced entry, bits 18:17 lane-group select, bit 16 keep-running-on-error, bit 15 loop forever, bits 14:12 skip gap, bits 11:0 set count.

Top module: `lstp_seq`

## Requirements
- R1: A start accepted while idle with forced entry set makes the first symbol time after the start edge a data symbol time. With forced entry clear, TRAIN_LEN (default 4) training symbol times (`txKind`=1) come first.
- R2: A set is eight data symbol times (`txKind`=2) carrying pattern entries 0 to 7 in order on every lane. After the programmed number of sets comes exactly one electrical-idle symbol time (`txKind`=4) with `done` high, and then `txKind`=0 and `busy` low.
- R3: With a set count of 0 and loop forever clear, the first symbol time after start is electrical idle. No training, data or skip symbol times are sent.
- R4: With loop forever set, the set count is ignored and sets repeat until `stop` is pulsed. The run then finishes at the next set boundary, and electrical idle follows.
- R5: A non-zero skip gap N inserts one skip symbol time (`txKind`=3) after every N-th set. No skip follows the final set, and skips do not count toward the set count. A gap of 0 sends no skips.
- R6: Lane-group select 01 marks lanes whose index is a multiple of 4, and 10 marks lanes whose index is a multiple of 8. In the first symbol time of every set, a marked lane carries DELAY_SYM (default 0xF7) and its `delayMask` bit is high. Select 00 or 11 marks no lane.
- R7: With keep-running-on-error clear, an error during data or skip symbol times makes the next symbol time electrical idle with `done` high.
- R8: Each accepted error sets `errValid` and loads `errSet` with the 0-based index of the set in progress and `errLanes` with `errLaneMask`. With keep-running-on-error set, the run continues and a later error overwrites the status. `errClr` clears `errValid`.
- R9: Control word and pattern writes take effect only while idle. A start pulse while busy is ignored.
- R10: After reset `txKind` is 0 and `busy`, `done`, `errValid` and `delayMask` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Control word write strobe |
| cfgWrData | input | 20 | Control word |
| patWe | input | 1 | Pattern entry write strobe |
| patAddr | input | 3 | Pattern entry index |
| patData | input | SYM_W | Pattern entry value |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop request for continuous mode |
| errIn | input | 1 | Error pulse from the receive checker |
| errLaneMask | input | LANES | Lanes in error with `errIn` |
| errClr | input | 1 | Clears the error valid bit |
| txKind | output | 3 | 0 idle, 1 training, 2 data, 3 skip, 4 electrical idle |
| txLanes | output | LANES*SYM_W | Symbol per lane, lane 0 in the low bits |
| delayMask | output | LANES | Lanes carrying the delay symbol |
| busy | output | 1 | A run is in progress |
| done | output | 1 | High during the electrical-idle symbol time |
| errValid | output | 1 | Sticky error status valid |
| errSet | output | 12 | Set index captured at the error |
| errLanes | output | LANES | Lane mask captured at the error |

## Verification
The assertions assume that `errIn` and `stop` are single-cycle pulses driven away from the clock edge, and that the control word is changed only between runs. The assertions on set stepping, skip resumption and the frozen control word hold only under these conditions. The bench drives every input on the falling edge and holds strobes for one cycle. Deliberate writes and start pulses during a run are used only to show that they are dropped. Error pulses are placed at chosen symbol times of a forced-entry run, so the expected set index and halt cycle follow directly from the position in the run.

// File: rtl/lstp_pkg.sv
`timescale 1ns/1ps
package lstp_pkg;
  localparam int SET_LEN = 8;
  localparam int IDX_W = $clog2(SET_LEN);
  localparam int CNT_W = 12;
  localparam int CFG_W = 20;

  typedef enum logic [2:0] {
    K_IDLE  = 3'd0,
    K_TRAIN = 3'd1,
    K_DATA  = 3'd2,
    K_SKIP  = 3'd3,
    K_EIDLE = 3'd4
  } kind_e;

  typedef struct packed {
    logic             forceEntry;
    logic [1:0]       laneMod;
    logic             noStopOnErr;
    logic             loopForever;
    logic [2:0]       skipGap;
    logic [CNT_W-1:0] loopLimit;
  } cfg_t;

  typedef struct packed {
    kind_e            kind;
    logic [IDX_W-1:0] symIdx;
    logic [CNT_W-1:0] setIdx;
    logic             capErr;
    logic             isIdle;
  } ctl_s_t;
endpackage

// File: rtl/lstp_ctrl.sv
`timescale 1ns/1ps
module lstp_ctrl
  import lstp_pkg::*;
#(
  parameter int TRAIN_LEN = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   stop,
  input  logic   errIn,
  input  cfg_t   cfg,
  output ctl_s_t strobe,
  output logic   busy,
  output logic   done
);
  localparam int TW = (TRAIN_LEN > 1) ? $clog2(TRAIN_LEN) : 1;
  localparam logic [TW-1:0] TRAIN_LAST = TW'(TRAIN_LEN - 1);
  localparam logic [IDX_W-1:0] SYM_LAST = IDX_W'(SET_LEN - 1);

  kind_e            state;
  logic [IDX_W-1:0] symIdx;
  logic [CNT_W-1:0] setCnt;
  logic [2:0]       skipCnt;
  logic [TW-1:0]    trainCnt;
  logic             stopReq;

  logic             live, errAcc, errStop, setEnd, lastSet, skipDue;
  logic [CNT_W-1:0] nextSetCnt;

  always_comb begin
    live       = (state == K_DATA) || (state == K_SKIP);
    errAcc     = errIn && live;
    errStop    = errAcc && !cfg.noStopOnErr;
    setEnd     = (state == K_DATA) && (symIdx == SYM_LAST);
    nextSetCnt = setCnt + 1'b1;
    lastSet    = stopReq || stop ||
                 (!cfg.loopForever && (nextSetCnt == cfg.loopLimit));
    skipDue    = (cfg.skipGap != 3'd0) &&
                 (({1'b0, skipCnt} + 4'd1) == {1'b0, cfg.skipGap});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= K_IDLE;
      symIdx   <= '0;
      setCnt   <= '0;
      skipCnt  <= '0;
      trainCnt <= '0;
      stopReq  <= 1'b0;
    end else begin
      if (state == K_IDLE) stopReq <= 1'b0;
      else if (stop)       stopReq <= 1'b1;

      unique case (state)
        K_IDLE: if (start) begin
          symIdx   <= '0;
          setCnt   <= '0;
          skipCnt  <= '0;
          trainCnt <= '0;
          if (cfg.loopLimit == '0 && !cfg.loopForever) state <= K_EIDLE;
          else if (cfg.forceEntry)                     state <= K_DATA;
          else                                         state <= K_TRAIN;
        end
        K_TRAIN: begin
          if (trainCnt == TRAIN_LAST) state <= K_DATA;
          else trainCnt <= trainCnt + 1'b1;
        end
        K_DATA: begin
          if (errStop) state <= K_EIDLE;
          else begin
            symIdx <= symIdx + 1'b1;
            if (setEnd) begin
              setCnt <= nextSetCnt;
              if (lastSet) state <= K_EIDLE;
              else if (skipDue) begin
                state   <= K_SKIP;
                skipCnt <= '0;
              end else skipCnt <= skipCnt + 1'b1;
            end
          end
        end
        K_SKIP:  state <= errStop ? K_EIDLE : K_DATA;
        K_EIDLE: state <= K_IDLE;
        default: state <= K_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.kind   = state;
    strobe.symIdx = symIdx;
    strobe.setIdx = setCnt;
    strobe.capErr = errAcc;
    strobe.isIdle = (state == K_IDLE);
    busy          = (state != K_IDLE);
    done          = (state == K_EIDLE);
  end

  // R2: data symbol times step through the set without gaps
  a_r2_sym_step: assert property (@(posedge clk) disable iff (!rstN)
    (state == K_DATA && symIdx != SYM_LAST && !errIn)
    |=> (state == K_DATA && symIdx == $past(symIdx) + 1'b1));

  // R2: electrical idle lasts one symbol time
  a_r2_eidle_once: assert property (@(posedge clk) disable iff (!rstN)
    (state == K_EIDLE) |=> (state == K_IDLE));

  // R5: a skip is followed by the start of a fresh set
  a_r5_skip_resume: assert property (@(posedge clk) disable iff (!rstN)
    (state == K_SKIP && !errStop) |=> (state == K_DATA && symIdx == '0));

  // R7: an error with stopping enabled ends the run
  a_r7_err_halt: assert property (@(posedge clk) disable iff (!rstN)
    (errIn && live && !cfg.noStopOnErr) |=> (state == K_EIDLE));

  // R9: a start while busy does not restart counting
  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && state == K_DATA && symIdx != SYM_LAST && !errIn)
    |=> (setCnt == $past(setCnt)));
endmodule

// File: rtl/lstp_dpath.sv
`timescale 1ns/1ps
module lstp_dpath
  import lstp_pkg::*;
#(
  parameter int LANES = 8,
  parameter int SYM_W = 8,
  parameter logic [SYM_W-1:0] TRAIN_SYM = 'h4A,
  parameter logic [SYM_W-1:0] SKIP_SYM  = 'h1C,
  parameter logic [SYM_W-1:0] EIDLE_SYM = 'h7C,
  parameter logic [SYM_W-1:0] DELAY_SYM = 'hF7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctl_s_t                 strobe,
  input  logic                   cfgWe,
  input  logic [CFG_W-1:0]       cfgWrData,
  input  logic                   patWe,
  input  logic [IDX_W-1:0]       patAddr,
  input  logic [SYM_W-1:0]       patData,
  input  logic [LANES-1:0]       errLanesIn,
  input  logic                   errClr,
  output cfg_t                   cfgQ,
  output logic [2:0]             txKind,
  output logic [LANES*SYM_W-1:0] txLanes,
  output logic [LANES-1:0]       delayMask,
  output logic                   errValid,
  output logic [CNT_W-1:0]       errSet,
  output logic [LANES-1:0]       errLanes
);
  logic [SYM_W-1:0] patMem [SET_LEN];
  logic [SYM_W-1:0] baseSym;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
      for (int i = 0; i < SET_LEN; i++) patMem[i] <= '0;
    end else if (strobe.isIdle) begin
      if (cfgWe) cfgQ <= cfg_t'(cfgWrData);
      if (patWe) patMem[patAddr] <= patData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errSet   <= '0;
      errLanes <= '0;
    end else if (strobe.capErr) begin
      errValid <= 1'b1;
      errSet   <= strobe.setIdx;
      errLanes <= errLanesIn;
    end else if (errClr) begin
      errValid <= 1'b0;
    end
  end

  always_comb begin
    unique case (strobe.kind)
      K_TRAIN: baseSym = TRAIN_SYM;
      K_DATA:  baseSym = patMem[strobe.symIdx];
      K_SKIP:  baseSym = SKIP_SYM;
      K_EIDLE: baseSym = EIDLE_SYM;
      default: baseSym = '0;
    endcase
    txKind = strobe.kind;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam bit HIT4 = (l % 4) == 0;
    localparam bit HIT8 = (l % 8) == 0;
    logic inGroup;
    assign inGroup = (cfgQ.laneMod == 2'b01 && HIT4) ||
                     (cfgQ.laneMod == 2'b10 && HIT8);
    assign delayMask[l] = (strobe.kind == K_DATA) && (strobe.symIdx == '0) && inGroup;
    assign txLanes[l*SYM_W +: SYM_W] = delayMask[l] ? DELAY_SYM : baseSym;
  end

  // R9: control word is frozen while a run is in progress
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.isIdle |=> $stable(cfgQ));

  // R6: no more lanes marked than the densest group allows
  a_r6_mask_bound: assert property (@(posedge clk) disable iff (!rstN)
    $countones(delayMask) <= (LANES + 3) / 4);

  // R8: status becomes valid only because of an accepted error
  a_r8_valid_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errValid) |-> $past(strobe.capErr));
endmodule

// File: rtl/lstp_seq.sv
`timescale 1ns/1ps
module lstp_seq
  import lstp_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int SYM_W     = 8,
  parameter int TRAIN_LEN = 4,
  parameter logic [SYM_W-1:0] DELAY_SYM = 'hF7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [CFG_W-1:0]       cfgWrData,
  input  logic                   patWe,
  input  logic [IDX_W-1:0]       patAddr,
  input  logic [SYM_W-1:0]       patData,
  input  logic                   start,
  input  logic                   stop,
  input  logic                   errIn,
  input  logic [LANES-1:0]       errLaneMask,
  input  logic                   errClr,
  output logic [2:0]             txKind,
  output logic [LANES*SYM_W-1:0] txLanes,
  output logic [LANES-1:0]       delayMask,
  output logic                   busy,
  output logic                   done,
  output logic                   errValid,
  output logic [CNT_W-1:0]       errSet,
  output logic [LANES-1:0]       errLanes
);
  ctl_s_t strobe;
  cfg_t   cfgQ;

  lstp_ctrl #(.TRAIN_LEN(TRAIN_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .errIn(errIn),
    .cfg(cfgQ), .strobe(strobe), .busy(busy), .done(done)
  );

  lstp_dpath #(.LANES(LANES), .SYM_W(SYM_W), .DELAY_SYM(DELAY_SYM)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWe(cfgWe),
    .cfgWrData(cfgWrData), .patWe(patWe), .patAddr(patAddr),
    .patData(patData), .errLanesIn(errLaneMask), .errClr(errClr),
    .cfgQ(cfgQ), .txKind(txKind), .txLanes(txLanes), .delayMask(delayMask),
    .errValid(errValid), .errSet(errSet), .errLanes(errLanes)
  );
endmodule

// File: tb/lstp_seq_tb.sv
`timescale 1ns/1ps
module lstp_seq_tb_top;
  localparam int LANES = 8;
  localparam int SYM_W = 8;
  localparam int TRAIN_LEN = 4;
  localparam int LOGMAX = 250;

  logic clk = 0, rstN = 0;
  logic cfgWe = 0, patWe = 0, start = 0, stop = 0, errIn = 0, errClr = 0;
  logic [19:0] cfgWrData = '0;
  logic [2:0] patAddr = '0;
  logic [7:0] patData = '0;
  logic [7:0] errLaneMask = '0;
  logic [2:0] txKind;
  logic [63:0] txLanes;
  logic [7:0] delayMask, errLanes;
  logic busy, done, errValid;
  logic [11:0] errSet;

  int total = 0, bad = 0;
  logic [7:0] pat [8];
  logic [2:0] kLog [LOGMAX];
  logic [7:0] sLog [LOGMAX];
  logic [7:0] mLog [LOGMAX];
  logic       dLog [LOGMAX];
  int logLen;
  int hStop, hErr1, hErr2, hRestart, hWr;
  logic [7:0] hLanes1, hLanes2;

  always #2 clk = ~clk;

  lstp_seq dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWrData(cfgWrData),
    .patWe(patWe), .patAddr(patAddr), .patData(patData), .start(start),
    .stop(stop), .errIn(errIn), .errLaneMask(errLaneMask), .errClr(errClr),
    .txKind(txKind), .txLanes(txLanes), .delayMask(delayMask), .busy(busy),
    .done(done), .errValid(errValid), .errSet(errSet), .errLanes(errLanes)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] mkCfg(bit f, logic [1:0] md, bit ns, bit lf,
                                        logic [2:0] gap, logic [11:0] lim);
    return {f, md, ns, lf, gap, lim};
  endfunction

  task automatic writeCfg(input logic [19:0] v);
    @(negedge clk); cfgWe = 1; cfgWrData = v;
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic clearHooks();
    hStop = -1; hErr1 = -1; hErr2 = -1; hRestart = -1; hWr = -1;
    hLanes1 = '0; hLanes2 = '0;
  endtask

  task automatic runLog();
    int n;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    n = 0;
    while (txKind != 3'd0 && n < LOGMAX) begin
      kLog[n] = txKind; sLog[n] = txLanes[7:0]; mLog[n] = delayMask; dLog[n] = done;
      stop  = (n == hStop);
      errIn = (n == hErr1) || (n == hErr2);
      errLaneMask = (n == hErr1) ? hLanes1 : (n == hErr2) ? hLanes2 : '0;
      start = (n == hRestart);
      cfgWe = (n == hWr); cfgWrData = mkCfg(1, 0, 0, 0, 0, 12'd3);
      patWe = (n == hWr); patAddr = 0; patData = 8'hAA;
      @(negedge clk);
      n++;
    end
    stop = 0; errIn = 0; errLaneMask = 0; start = 0; cfgWe = 0; patWe = 0;
    logLen = n;
  endtask

  task automatic checkSeq(input bit f, input int lim, input int gap,
                          input int md, input string req);
    logic [2:0] ek [LOGMAX];
    logic [7:0] es [LOGMAX];
    logic [7:0] em [LOGMAX];
    int n = 0;
    int bad1 = -1;
    if (lim != 0) begin
      if (!f) for (int i = 0; i < TRAIN_LEN; i++) begin
        ek[n] = 1; es[n] = 8'h4A; em[n] = 0; n++;
      end
      for (int s = 0; s < lim; s++) begin
        for (int k = 0; k < 8; k++) begin
          ek[n] = 2; em[n] = 0; es[n] = pat[k];
          if (k == 0 && md == 1) begin em[n] = 8'h11; es[n] = 8'hF7; end
          if (k == 0 && md == 2) begin em[n] = 8'h01; es[n] = 8'hF7; end
          n++;
        end
        if (s != lim - 1 && gap != 0 && ((s + 1) % gap) == 0) begin
          ek[n] = 3; es[n] = 8'h1C; em[n] = 0; n++;
        end
      end
    end
    ek[n] = 4; es[n] = 8'h7C; em[n] = 0; n++;
    check(logLen == n, req, "run length", logLen, n);
    for (int i = 0; i < n && i < logLen; i++)
      if (bad1 < 0 && (kLog[i] != ek[i] || sLog[i] != es[i] || mLog[i] != em[i] ||
                       dLog[i] != (i == n - 1))) bad1 = i;
    if (bad1 >= 0)
      check(0, req, "kind/sym/mask at step", {kLog[bad1], sLog[bad1], mLog[bad1]},
            {ek[bad1], es[bad1], em[bad1]});
    else check(1, req, "sequence", 0, 0);
  endtask

  task automatic t_reset();
    check(txKind == 0 && !busy && !done && !errValid && delayMask == 0,
          "R10", "reset outputs", {txKind, busy, done, errValid, delayMask}, 0);
  endtask

  task automatic t_forced();
    clearHooks(); writeCfg(mkCfg(1, 0, 0, 0, 0, 12'd2)); runLog();
    checkSeq(1, 2, 0, 0, "R1 R2 forced");
    check(!busy, "R2", "busy low after run", busy, 0);
  endtask

  task automatic t_train();
    clearHooks(); writeCfg(mkCfg(0, 0, 0, 0, 0, 12'd1)); runLog();
    checkSeq(0, 1, 0, 0, "R1 training");
  endtask

  task automatic t_zero();
    clearHooks(); writeCfg(mkCfg(0, 0, 0, 0, 3'd1, 12'd0)); runLog();
    checkSeq(0, 0, 0, 0, "R3 zero count");
  endtask

  task automatic t_skip();
    clearHooks(); writeCfg(mkCfg(1, 0, 0, 0, 3'd1, 12'd3)); runLog();
    checkSeq(1, 3, 1, 0, "R5 gap1");
    writeCfg(mkCfg(1, 0, 0, 0, 3'd2, 12'd5)); runLog();
    checkSeq(1, 5, 2, 0, "R5 gap2");
  endtask

  task automatic t_delay();
    clearHooks();
    writeCfg(mkCfg(1, 2'b01, 0, 0, 0, 12'd2)); runLog(); checkSeq(1, 2, 0, 1, "R6 mod4");
    writeCfg(mkCfg(1, 2'b10, 0, 0, 0, 12'd1)); runLog(); checkSeq(1, 1, 0, 2, "R6 mod8");
    writeCfg(mkCfg(1, 2'b11, 0, 0, 0, 12'd1)); runLog(); checkSeq(1, 1, 0, 3, "R6 reserved");
  endtask

  task automatic t_forever();
    for (int lim = 0; lim < 3; lim += 2) begin
      bit ok = 1;
      clearHooks(); hStop = 37;
      writeCfg(mkCfg(1, 0, 0, 1, 0, 12'(lim))); runLog();
      check(logLen == 41, "R4", "continuous run length", logLen, 41);
      for (int i = 0; i < 40 && i < logLen; i++) if (kLog[i] != 2) ok = 0;
      check(ok && logLen == 41 && kLog[40] == 4 && dLog[40], "R4",
            "data until stop boundary", kLog[40], 4);
    end
  endtask

  task automatic t_errStop();
    clearHooks(); hErr1 = 10; hLanes1 = 8'h24;
    writeCfg(mkCfg(1, 0, 0, 0, 0, 12'd4)); runLog();
    check(logLen == 12 && kLog[11] == 4 && dLog[11], "R7", "halt after error",
          logLen, 12);
    check(errValid && errSet == 1 && errLanes == 8'h24, "R8", "captured status",
          {errValid, errSet, errLanes}, {1'b1, 12'd1, 8'h24});
    @(negedge clk); errClr = 1; @(negedge clk); errClr = 0;
    check(!errValid, "R8", "clear valid", errValid, 0);
  endtask

  task automatic t_errCont();
    clearHooks(); hErr1 = 5; hLanes1 = 8'h01; hErr2 = 20; hLanes2 = 8'h80;
    writeCfg(mkCfg(1, 0, 1, 0, 0, 12'd4)); runLog();
    check(logLen == 33 && kLog[32] == 4, "R8", "run continues", logLen, 33);
    check(errValid && errSet == 2 && errLanes == 8'h80, "R8", "later error overwrites",
          {errValid, errSet, errLanes}, {1'b1, 12'd2, 8'h80});
  endtask

  task automatic t_busyIgnore();
    clearHooks(); hWr = 3; hRestart = 5;
    writeCfg(mkCfg(1, 0, 0, 0, 0, 12'd1)); runLog();
    checkSeq(1, 1, 0, 0, "R9 start while busy");
    clearHooks(); runLog();
    checkSeq(1, 1, 0, 0, "R9 writes while busy");
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) pat[k] = 8'h10 + 8'(k * 7);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); patWe = 1; patAddr = 3'(k); patData = pat[k];
    end
    @(negedge clk); patWe = 0;
    t_forced();
    t_train();
    t_zero();
    t_skip();
    t_delay();
    t_forever();
    t_errStop();
    t_errCont();
    t_busyIgnore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule